// File: doc/BRIEF.md
# Two-Channel Programmable Interrupt Controller

This block gathers a set of physical interrupt lines from the chip and presents them to a processor core as two active-low request outputs. One output is the fast channel, which the core treats as its higher-priority request. The other is the normal channel. The fast channel owns 4 logical interrupts and the normal channel owns 20.

Every logical interrupt has its own control register. That register picks the physical line that feeds the interrupt, chooses level or edge triggering, sets the active polarity, and gates the interrupt on or off. Both channels use identical logic but keep fully separate state. Software reads each channel's masked pending bits from a status word. It acknowledges edge events by writing ones to that word.

Physical lines are asynchronous to the block. They pass through a two-flop synchronizer, and a third stage feeds edge detection. Register reads are combinational. Writes take effect on the clock edge where `wr_en_i` is high.

Top module: `intc_two_chan`

## Requirements
- R1: After reset both request outputs are high, every control register reads 0 and both status words read 0.
- R2: A control word holds the source line index in bits [2:0], edge mode in bit 8, active-low polarity in bit 9 and enable in bit 10, and reads back exactly those bits with all others 0. Fast interrupt k sits at address k (0..3). Normal interrupt k sits at address 32+k (0..19). Unmapped addresses such as 10 read 0.
- R3: A logical interrupt responds only to the physical line its control word selects; activity on any other line leaves its status bit unchanged.
- R4: In level mode, with active-high polarity, the status bit equals the synchronized input. Writes to the status word do not clear it.
- R5: Active-low polarity inverts the input before level or edge evaluation. A low level, or a high-to-low transition, counts as active.
- R6: In edge mode, an inactive-to-active transition sets a pending bit. That bit stays set after the input returns to inactive.
- R7: Writing the status word of a channel (address 62 fast, 63 normal) clears each edge pending bit whose data bit is 1 and leaves the bits written as 0 untouched. Bit k of the status word is logical interrupt k. A new edge in the same cycle wins over the clear.
- R8: A disabled logical interrupt contributes nothing to its channel's status word or request output, even when its source toggles.
- R9: A channel's request output is low in the cycle after any bit of that channel's status word is set, and high in the cycle after none is.
- R10: The two channels are independent. Events, configuration and clears on one channel never change the other channel's status word or request output.
- R11: Writing a logical interrupt's control register clears its edge pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phys_i | input | 8 | Asynchronous physical interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| fast_req_no | output | 1 | Fast channel request, active low |
| norm_req_no | output | 1 | Normal channel request, active low |

## Verification
Each result has a fixed latency, counted from the edge where a physical line changes:
- A level interrupt appears in the status word after two clock edges.
- A level interrupt reaches the request output after three edges.
- An edge interrupt latches on the third edge.
- An edge interrupt drives the request output on the fourth edge.

Register writes and clears change the status word at the write edge, and the request output one edge later. The bench therefore drives inputs at falling edges and waits at least four cycles after a line change before sampling. It waits at least one full cycle after a register write. Status words are read through the normal read port at falling edges.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W   = 32;
  localparam int EDGE_BIT = 8;
  localparam int LOW_BIT  = 9;
  localparam int EN_BIT   = 10;

  typedef struct packed {
    logic en;
    logic act_low;
    logic edge_mode;
  } trig_t;

  function automatic trig_t decode_trig(input logic [DATA_W-1:0] w);
    trig_t t;
    t.en        = w[EN_BIT];
    t.act_low   = w[LOW_BIT];
    t.edge_mode = w[EDGE_BIT];
    return t;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] now_o,
  output logic [W-1:0] old_o
);
  logic [W-1:0] meta_q, now_q, old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      now_q  <= '0;
      old_q  <= '0;
    end else begin
      meta_q <= async_i;
      now_q  <= meta_q;
      old_q  <= now_q;
    end
  end

  assign now_o = now_q;
  assign old_o = old_q;
endmodule

// File: rtl/intc_chan.sv
module intc_chan
  import intc_pkg::*;
#(
  parameter int N_LOG  = 4,
  parameter int N_PHYS = 8,
  localparam int SRC_W = (N_PHYS > 1) ? $clog2(N_PHYS) : 1,
  localparam int IDX_W = (N_LOG > 1) ? $clog2(N_LOG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PHYS-1:0] phys_now_i,
  input  logic [N_PHYS-1:0] phys_old_i,
  input  logic              ctrl_we_i,
  input  logic [IDX_W-1:0]  ctrl_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_we_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] ctrl_rdata_o,
  output logic [N_LOG-1:0]  status_o,
  output logic              irq_no
);
  logic [DATA_W-1:0] ctrl_word [N_LOG];
  logic              unused_wdata;
  logic              irq_nq;

  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < N_LOG; i++) begin : g_log
    logic [SRC_W-1:0]  src_q;
    trig_t             trig_q;
    logic              latch_q;
    logic              act_now, act_old, rise, hit_ctrl, clr;
    logic [DATA_W-1:0] word;

    assign hit_ctrl = ctrl_we_i && (ctrl_idx_i == IDX_W'(i));
    assign clr      = clr_we_i && wdata_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q  <= '0;
        trig_q <= '0;
      end else if (hit_ctrl) begin
        src_q  <= wdata_i[SRC_W-1:0];
        trig_q <= decode_trig(wdata_i);
      end
    end

    // polarity-corrected view of the selected line
    assign act_now = phys_now_i[src_q] ^ trig_q.act_low;
    assign act_old = phys_old_i[src_q] ^ trig_q.act_low;
    assign rise    = trig_q.edge_mode && act_now && !act_old;

    // reconfiguration discards a stale event; a fresh edge beats a W1C clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       latch_q <= 1'b0;
      else if (hit_ctrl) latch_q <= 1'b0;
      else if (rise)     latch_q <= 1'b1;
      else if (clr)      latch_q <= 1'b0;
    end

    assign status_o[i] = trig_q.en && (trig_q.edge_mode ? latch_q : act_now);

    always_comb begin
      word = '0;
      word[SRC_W-1:0] = src_q;
      word[EDGE_BIT]  = trig_q.edge_mode;
      word[LOW_BIT]   = trig_q.act_low;
      word[EN_BIT]    = trig_q.en;
    end
    assign ctrl_word[i] = word;

    p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latch_q && !hit_ctrl && !clr |=> latch_q);
    p_w1c_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr && !rise && !hit_ctrl |=> !latch_q);
    p_cfg_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_ctrl |=> !latch_q);
  end

  always_comb begin
    ctrl_rdata_o = '0;
    for (int k = 0; k < N_LOG; k++)
      if (rd_idx_i == IDX_W'(k)) ctrl_rdata_o = ctrl_word[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_nq <= 1'b1;
    else         irq_nq <= ~|status_o;
  end
  assign irq_no = irq_nq;

  p_req_assert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_o) |=> !irq_no);
  p_req_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|status_o) |=> irq_no);
endmodule

// File: rtl/intc_two_chan.sv
module intc_two_chan
  import intc_pkg::*;
#(
  parameter int N_PHYS    = 8,
  parameter int N_FAST    = 4,
  parameter int N_NORM    = 20,
  parameter int ADDR_W    = 6,
  parameter int NORM_BASE = 32,
  parameter int FAST_STAT = 62,
  parameter int NORM_STAT = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PHYS-1:0] phys_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              fast_req_no,
  output logic              norm_req_no
);
  localparam int FI_W = (N_FAST > 1) ? $clog2(N_FAST) : 1;
  localparam int NI_W = (N_NORM > 1) ? $clog2(N_NORM) : 1;
  localparam logic [ADDR_W-1:0] FAST_END_A  = ADDR_W'(N_FAST);
  localparam logic [ADDR_W-1:0] NORM_BASE_A = ADDR_W'(NORM_BASE);
  localparam logic [ADDR_W-1:0] NORM_END_A  = ADDR_W'(NORM_BASE + N_NORM);
  localparam logic [ADDR_W-1:0] FSTAT_A     = ADDR_W'(FAST_STAT);
  localparam logic [ADDR_W-1:0] NSTAT_A     = ADDR_W'(NORM_STAT);

  logic [N_PHYS-1:0] ph_now, ph_old;
  logic              fast_hit, norm_hit;
  logic [ADDR_W-1:0] norm_off;
  logic              unused_addr;
  logic [DATA_W-1:0] f_ctrl, n_ctrl;
  logic [N_FAST-1:0] f_stat;
  logic [N_NORM-1:0] n_stat;

  assign fast_hit    = addr_i < FAST_END_A;
  assign norm_hit    = (addr_i >= NORM_BASE_A) && (addr_i < NORM_END_A);
  assign norm_off    = addr_i - NORM_BASE_A;
  assign unused_addr = ^{norm_off, addr_i};

  intc_sync #(.W(N_PHYS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(phys_i),
    .now_o  (ph_now),
    .old_o  (ph_old)
  );

  intc_chan #(.N_LOG(N_FAST), .N_PHYS(N_PHYS)) i_fast (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phys_now_i  (ph_now),
    .phys_old_i  (ph_old),
    .ctrl_we_i   (wr_en_i && fast_hit),
    .ctrl_idx_i  (addr_i[FI_W-1:0]),
    .wdata_i     (wdata_i),
    .clr_we_i    (wr_en_i && (addr_i == FSTAT_A)),
    .rd_idx_i    (addr_i[FI_W-1:0]),
    .ctrl_rdata_o(f_ctrl),
    .status_o    (f_stat),
    .irq_no      (fast_req_no)
  );

  intc_chan #(.N_LOG(N_NORM), .N_PHYS(N_PHYS)) i_norm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phys_now_i  (ph_now),
    .phys_old_i  (ph_old),
    .ctrl_we_i   (wr_en_i && norm_hit),
    .ctrl_idx_i  (norm_off[NI_W-1:0]),
    .wdata_i     (wdata_i),
    .clr_we_i    (wr_en_i && (addr_i == NSTAT_A)),
    .rd_idx_i    (norm_off[NI_W-1:0]),
    .ctrl_rdata_o(n_ctrl),
    .status_o    (n_stat),
    .irq_no      (norm_req_no)
  );

  always_comb begin
    rdata_o = '0;
    if (fast_hit)               rdata_o = f_ctrl;
    else if (norm_hit)          rdata_o = n_ctrl;
    else if (addr_i == FSTAT_A) rdata_o = DATA_W'(f_stat);
    else if (addr_i == NSTAT_A) rdata_o = DATA_W'(n_stat);
  end

  // a write aimed at one channel leaves the other's request level unchanged
  p_fast_indep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (norm_hit || addr_i == NSTAT_A) && $stable(f_stat) |=> $stable(fast_req_no));
  p_norm_indep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (fast_hit || addr_i == FSTAT_A) && $stable(n_stat) |=> $stable(norm_req_no));
endmodule

// File: tb/test_intc_two_chan.sv
module test_intc_two_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  phys = 8'h02;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fast_n, norm_n;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  intc_two_chan i_intc_two_chan (
    .clk_i(clk), .rst_ni(rst_n), .phys_i(phys), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .fast_req_no(fast_n), .norm_req_no(norm_n)
  );

  typedef struct packed {
    logic [7:0]  ph;
    logic [3:0]  fst;
    logic [19:0] nst;
    logic        fq;
    logic        nq;
  } vec_t;

  // fast0: line0 high level; fast1: line1 low level; norm0: line2; norm19: line7
  localparam vec_t TBL [7] = '{
    '{8'h02, 4'h0, 20'h00000, 1'b1, 1'b1},
    '{8'h03, 4'h1, 20'h00000, 1'b0, 1'b1},
    '{8'h00, 4'h2, 20'h00000, 1'b0, 1'b1},
    '{8'h06, 4'h0, 20'h00001, 1'b1, 1'b0},
    '{8'h82, 4'h0, 20'h80000, 1'b1, 1'b0},
    '{8'h7A, 4'h0, 20'h00000, 1'b1, 1'b1},
    '{8'h85, 4'h3, 20'h80001, 1'b0, 1'b0}
  };

  function automatic logic [31:0] mk(input int src, input bit edg, input bit low, input bit en);
    logic [31:0] w = '0;
    w[2:0] = 3'(src);
    w[8] = edg;
    w[9] = low;
    w[10] = en;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [7:0] hi, input logic [7:0] idle);
    @(negedge clk);
    phys = hi;
    cyc(3);
    phys = idle;
    cyc(4);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 fast_req", 32'(fast_n), 32'd1);
    chk("R1 norm_req", 32'(norm_n), 32'd1);
    rd(6'd0, d);  chk("R1 ctrl0", d, 32'd0);
    rd(6'd62, d); chk("R1 fast status", d, 32'd0);
    rd(6'd63, d); chk("R1 norm status", d, 32'd0);

    wr(6'd0,  mk(0, 0, 0, 1));
    wr(6'd1,  mk(1, 0, 1, 1));
    wr(6'd32, mk(2, 0, 0, 1));
    wr(6'd51, mk(7, 0, 0, 1));
    // R2 read-back and field masking
    rd(6'd1, d);  chk("R2 ctrl fast1", d, 32'h0000_0601);
    rd(6'd51, d); chk("R2 ctrl norm19", d, 32'h0000_0407);
    rd(6'd10, d); chk("R2 unmapped", d, 32'd0);
    wr(6'd2, 32'hFFFF_FFFF);
    rd(6'd2, d);  chk("R2 field mask", d, 32'h0000_0707);
    wr(6'd2, 32'd0);

    // R3 R4 R5 R9 level table
    foreach (TBL[i]) begin
      @(negedge clk);
      phys = TBL[i].ph;
      cyc(4);
      chk($sformatf("R4 fast req vec%0d", i), 32'(fast_n), 32'(TBL[i].fq));
      chk($sformatf("R9 norm req vec%0d", i), 32'(norm_n), 32'(TBL[i].nq));
      rd(6'd62, d); chk($sformatf("R5 fast status vec%0d", i), d, 32'(TBL[i].fst));
      rd(6'd63, d); chk($sformatf("R3 norm status vec%0d", i), d, 32'(TBL[i].nst));
    end
    @(negedge clk);
    phys = 8'h02;
    cyc(4);

    // R6 rising edge latch on norm5 / line3
    wr(6'd37, mk(3, 1, 0, 1));
    pulse(8'h0A, 8'h02);
    rd(6'd63, d); chk("R6 latched", d, 32'h20);
    chk("R6 norm req", 32'(norm_n), 32'd0);
    rd(6'd62, d); chk("R10 fast untouched", d, 32'd0);
    chk("R10 fast req idle", 32'(fast_n), 32'd1);
    // R7 write-one-to-clear
    wr(6'd63, 32'd0);
    rd(6'd63, d); chk("R7 zero write keeps", d, 32'h20);
    wr(6'd63, 32'h20);
    cyc(1);
    rd(6'd63, d); chk("R7 cleared", d, 32'd0);
    chk("R7 norm req released", 32'(norm_n), 32'd1);

    // R5 falling edge, active-low, fast2 / line4
    @(negedge clk);
    phys = 8'h12;
    cyc(4);
    wr(6'd2, mk(4, 1, 1, 1));
    @(negedge clk);
    phys = 8'h02;
    cyc(4);
    rd(6'd62, d); chk("R5 falling edge", d, 32'h4);
    chk("R5 fast req", 32'(fast_n), 32'd0);
    @(negedge clk);
    phys = 8'h12;
    cyc(4);
    rd(6'd62, d); chk("R6 held after release", d, 32'h4);
    wr(6'd62, 32'h4);
    cyc(1);
    rd(6'd62, d); chk("R7 fast cleared", d, 32'd0);
    wr(6'd2, 32'd0);
    @(negedge clk);
    phys = 8'h02;
    cyc(4);

    // R8 disabled interrupt
    wr(6'd38, mk(5, 1, 0, 0));
    pulse(8'h22, 8'h02);
    rd(6'd63, d); chk("R8 disabled status", d, 32'd0);
    chk("R8 disabled req", 32'(norm_n), 32'd1);

    // R11 control write drops the latch
    pulse(8'h0A, 8'h02);
    rd(6'd63, d); chk("R11 latched first", d, 32'h20);
    wr(6'd37, mk(3, 1, 0, 1));
    cyc(1);
    rd(6'd63, d); chk("R11 cleared by ctrl write", d, 32'd0);
    chk("R11 norm req", 32'(norm_n), 32'd1);

    // R10 clears stay in their own channel; R4 level ignores W1C
    @(negedge clk);
    phys = 8'h03;
    cyc(4);
    pulse(8'h0B, 8'h03);
    rd(6'd63, d); chk("R10 norm set", d, 32'h20);
    wr(6'd63, 32'hFFFF_FFFF);
    cyc(1);
    rd(6'd63, d); chk("R10 norm cleared", d, 32'd0);
    rd(6'd62, d); chk("R10 fast kept", d, 32'h1);
    chk("R10 fast req kept", 32'(fast_n), 32'd0);
    wr(6'd62, 32'hFFFF_FFFF);
    cyc(1);
    rd(6'd62, d); chk("R4 level ignores clear", d, 32'h1);
    @(negedge clk);
    phys = 8'h02;
    cyc(4);
    rd(6'd62, d); chk("R4 level drops", d, 32'd0);
    chk("R9 fast req released", 32'(fast_n), 32'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule